// File: doc/BRIEF.md
# Terminated Rate-1/2 Convolutional Encoder with Block Interleaver

This block protects one short voice packet at a time against channel errors. Data bits arrive serially. Each accepted bit passes through a constraint-length-3, rate one-half convolutional encoder. After the final data bit, the encoder is fed two zero bits. These flush the trellis back to the all-zero state, so the decoder can assume a known end state.

Every coded bit, tail bits included, is stored in an internal block interleaver. Once the whole terminated codeword is stored, the interleaver is read out serially in a permuted order. A burst of consecutive channel errors then falls on coded bits that lie far apart in the codeword. Two packet sizes are supported: 128 data bits, for sixteen 8-bit samples, and 256 data bits, for sixteen 16-bit words that hold 14-bit samples padded to 16 bits.

While a finished packet is being shifted out, the input side is stalled. The encoder register is cleared before the next packet starts, so every packet is encoded independently.

Top module: `pkt_fec_interleaver`

## Requirements
- R1: For data bit d(t), two coded bits are produced. The first is A = d(t) xor d(t-1) xor d(t-2), from taps 111. The second is B = d(t) xor d(t-2), from taps 101. A has coded index 2t and B has coded index 2t+1, where t counts from 0 within the packet.
- R2: After the last data bit, two zero input bits are encoded. They append 4 tail coded bits, at indices 2N to 2N+3, and the encoder state is zero afterwards.
- R3: len_sel is sampled together with the first accepted data bit of a packet. The value 0 selects N=128 data bits and a coded length of 260. The value 1 selects N=256 data bits and a coded length of 516. Later changes of len_sel have no effect on the packet in progress.
- R4: Coded index k is stored at row k/C, column k%C. The 128-bit mode uses 4 rows by 65 columns; the 256-bit mode uses 12 rows by 43 columns. Output proceeds column by column starting at column 0, and within each column from row 0 upward. Cells whose index is at or beyond the coded length are skipped.
- R5: in_ready is high only while data bits are being taken. From the cycle after the last data bit is accepted until the final coded bit of that packet appears on the output, in_ready is low, and in_valid and in_bit have no effect.
- R6: Each packet yields exactly as many out_valid pulses as its coded length. out_last is high together with out_valid on the final pulse only.
- R7: The encoder register holds zero when the first data bit of every packet is accepted, so a packet's output does not depend on earlier packets.
- R8: While rst_n is low, out_valid and out_last are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A data bit is offered on in_bit |
| in_bit | input | 1 | Serial data bit |
| len_sel | input | 1 | Packet size select, sampled with the first bit (0: 128, 1: 256) |
| in_ready | output | 1 | The block accepts a data bit this cycle |
| out_valid | output | 1 | out_bit carries an interleaved coded bit |
| out_bit | output | 1 | Serial interleaved coded bit |
| out_last | output | 1 | Marks the final coded bit of a packet |

## Verification
The bench targets the following cases:

- **Single leading one, then zeros.** This isolates the tap patterns. A swapped generator or a swapped A/B order would show up as bits in the wrong interleaved positions.
- **Packet of all ones.** The trellis state is nonzero at the end of the data, so a missing or shortened tail would corrupt the last four coded bits and the output count.
- **Input held valid, with len_sel flipped, during a drain.** This exposes a design that keeps accepting bits while draining, or that re-samples the size mid-packet. Either fault shifts every later bit.
- **Packets back to back, with idle gaps.** These catch a design that carries encoder state across packet boundaries, or that uses the wrong geometry for one of the two modes.

// File: rtl/cilv_pkg.sv
package cilv_pkg;

  typedef enum logic [1:0] {
    ST_DATA  = 2'd0,
    ST_TAIL  = 2'd1,
    ST_DRAIN = 2'd2
  } phase_t;

endpackage

// File: rtl/cilv_encoder.sv
module cilv_encoder #(
  parameter int          K   = 3,
  parameter logic [K-1:0] G_A = 3'b111,
  parameter logic [K-1:0] G_B = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         din,
  output logic         code_a,
  output logic         code_b,
  output logic [K-2:0] state
);

  logic [K-2:0] sr_q, sr_d;
  logic [K-1:0] win;

  // win[0] is the current bit, win[j] the bit j steps back
  assign win    = {sr_q, din};
  assign code_a = ^(win & G_A);
  assign code_b = ^(win & G_B);
  assign state  = sr_q;

  always_comb begin
    sr_d = sr_q;
    if (clr)     sr_d = '0;
    else if (en) sr_d = win[K-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/cilv_bitram.sv
module cilv_bitram #(
  parameter int DEPTH = 516,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [1:0]    wd,
  input  logic [AW-1:0] raddr,
  output logic          rd
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr]          <= wd[0];
      mem[waddr + AW'(1)] <= wd[1];
    end
  end

  assign rd = mem[raddr];

  // R3: the coded pair always lands inside the codeword storage
  p_waddr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) <= DEPTH - 2));

endmodule

// File: rtl/cilv_ctrl.sv
module cilv_ctrl
  import cilv_pkg::*;
#(
  parameter int SHORT_BITS = 128,
  parameter int LONG_BITS  = 256,
  parameter int MEM_M      = 2,
  parameter int ROWS_S     = 4,
  parameter int COLS_S     = 65,
  parameter int ROWS_L     = 12,
  parameter int COLS_L     = 43,
  parameter int AW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          len_sel,
  output logic          in_ready,
  output logic          accept,
  output logic          first_bit,
  output logic          enc_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] mem_raddr,
  output logic          rd_ok,
  output logic          rd_last,
  output phase_t        phase
);

  localparam int DW     = $clog2(LONG_BITS);
  localparam int TW     = $clog2(MEM_M + 1);
  localparam int ROWMAX = (ROWS_L > ROWS_S) ? ROWS_L : ROWS_S;
  localparam int COLMAX = (COLS_L > COLS_S) ? COLS_L : COLS_S;
  localparam int RW     = $clog2(ROWMAX + 1);
  localparam int CW     = $clog2(COLMAX + 1);

  phase_t        phase_q, phase_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] ocnt_q, ocnt_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic          lsel_q, lsel_d;

  logic lsel_cur;
  int   dlen_i, cwlen_i, rows_i, cols_i, raddr_i;

  assign phase     = phase_q;
  assign in_ready  = (phase_q == ST_DATA);
  assign accept    = in_ready && in_valid;
  assign first_bit = (phase_q == ST_DATA) && (dcnt_q == '0);
  assign lsel_cur  = first_bit ? len_sel : lsel_q;

  always_comb begin
    dlen_i  = lsel_cur ? LONG_BITS : SHORT_BITS;
    cwlen_i = 2 * (dlen_i + MEM_M);
    rows_i  = lsel_cur ? ROWS_L : ROWS_S;
    cols_i  = lsel_cur ? COLS_L : COLS_S;
    raddr_i = int'(row_q) * cols_i + int'(col_q);
  end

  assign mem_we    = accept || (phase_q == ST_TAIL);
  assign mem_waddr = wptr_q;
  assign mem_raddr = AW'(raddr_i);
  assign rd_ok     = (phase_q == ST_DRAIN) && (raddr_i < cwlen_i);
  assign rd_last   = rd_ok && (int'(ocnt_q) == cwlen_i - 1);
  assign enc_clr   = rd_last;

  always_comb begin
    phase_d = phase_q;
    dcnt_d  = dcnt_q;
    tcnt_d  = tcnt_q;
    wptr_d  = wptr_q;
    ocnt_d  = ocnt_q;
    row_d   = row_q;
    col_d   = col_q;
    lsel_d  = (accept && first_bit) ? len_sel : lsel_q;
    case (phase_q)
      ST_DATA: begin
        if (accept) begin
          wptr_d = wptr_q + AW'(2);
          if (int'(dcnt_q) == dlen_i - 1) begin
            phase_d = ST_TAIL;
            dcnt_d  = '0;
            tcnt_d  = '0;
          end else begin
            dcnt_d = dcnt_q + DW'(1);
          end
        end
      end
      ST_TAIL: begin
        wptr_d = wptr_q + AW'(2);
        if (int'(tcnt_q) == MEM_M - 1) begin
          phase_d = ST_DRAIN;
          row_d   = '0;
          col_d   = '0;
          ocnt_d  = '0;
        end else begin
          tcnt_d = tcnt_q + TW'(1);
        end
      end
      ST_DRAIN: begin
        if (int'(row_q) == rows_i - 1) begin
          row_d = '0;
          col_d = col_q + CW'(1);
        end else begin
          row_d = row_q + RW'(1);
        end
        if (rd_ok) ocnt_d = ocnt_q + AW'(1);
        if (rd_last) begin
          phase_d = ST_DATA;
          wptr_d  = '0;
        end
      end
      default: phase_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_DATA;
      dcnt_q  <= '0;
      tcnt_q  <= '0;
      wptr_q  <= '0;
      ocnt_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      lsel_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dcnt_q  <= dcnt_d;
      tcnt_q  <= tcnt_d;
      wptr_q  <= wptr_d;
      ocnt_q  <= ocnt_d;
      row_q   <= row_d;
      col_q   <= col_d;
      lsel_q  <= lsel_d;
    end
  end

  // R5: no write into the array once its contents are being read out
  p_no_write_in_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_DRAIN) |=> ($past(mem_we) == 1'b0));

endmodule

// File: rtl/pkt_fec_interleaver.sv
module pkt_fec_interleaver
  import cilv_pkg::*;
#(
  parameter int          SHORT_BITS = 128,
  parameter int          LONG_BITS  = 256,
  parameter int          K          = 3,
  parameter logic [K-1:0] G_A       = 3'b111,
  parameter logic [K-1:0] G_B       = 3'b101,
  parameter int          ROWS_S     = 4,
  parameter int          COLS_S     = 65,
  parameter int          ROWS_L     = 12,
  parameter int          COLS_L     = 43
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic len_sel,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_last
);

  localparam int MEM_M  = K - 1;
  localparam int CW_MAX = 2 * (LONG_BITS + MEM_M);
  localparam int AW     = $clog2(CW_MAX);

  logic          accept, first_bit, enc_clr, mem_we, rd_ok, rd_last, rd_bit;
  logic          enc_din, code_a, code_b;
  logic [K-2:0]  enc_state;
  logic [AW-1:0] mem_waddr, mem_raddr;
  phase_t        phase;

  logic ov_q, ov_d, ob_q, ob_d, ol_q, ol_d;

  cilv_ctrl #(
    .SHORT_BITS (SHORT_BITS),
    .LONG_BITS  (LONG_BITS),
    .MEM_M      (MEM_M),
    .ROWS_S     (ROWS_S),
    .COLS_S     (COLS_S),
    .ROWS_L     (ROWS_L),
    .COLS_L     (COLS_L),
    .AW         (AW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .len_sel   (len_sel),
    .in_ready  (in_ready),
    .accept    (accept),
    .first_bit (first_bit),
    .enc_clr   (enc_clr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_raddr (mem_raddr),
    .rd_ok     (rd_ok),
    .rd_last   (rd_last),
    .phase     (phase)
  );

  // tail cycles feed zeros into the encoder
  assign enc_din = accept ? in_bit : 1'b0;

  cilv_encoder #(
    .K   (K),
    .G_A (G_A),
    .G_B (G_B)
  ) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mem_we),
    .clr    (enc_clr),
    .din    (enc_din),
    .code_a (code_a),
    .code_b (code_b),
    .state  (enc_state)
  );

  cilv_bitram #(
    .DEPTH (CW_MAX),
    .AW    (AW)
  ) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wd    ({code_b, code_a}),
    .raddr (mem_raddr),
    .rd    (rd_bit)
  );

  always_comb begin
    ov_d = rd_ok;
    ol_d = rd_last;
    ob_d = ob_q;
    if (rd_ok) ob_d = rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ob_q <= 1'b0;
      ol_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      ob_q <= ob_d;
      ol_q <= ol_d;
    end
  end

  assign out_valid = ov_q;
  assign out_bit   = ob_q;
  assign out_last  = ol_q;

  // R2: the flushed trellis is back in state zero when readout begins
  p_term_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == ST_DRAIN) && ($past(phase) == ST_TAIL)) |-> (enc_state == '0));

  // R7: every packet starts from a cleared encoder
  p_clear_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first_bit) |-> (enc_state == '0));

  // R5: input is held off while non-final coded bits are leaving
  p_stall_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);

  // R6: the end marker only ever rides on a valid coded bit
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6: two end markers never appear back to back
  p_last_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_last);

endmodule

// File: tb/pkt_fec_interleaver_tb.sv
`timescale 1ns/1ps
module pkt_fec_interleaver_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic len_sel = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;

  always #2.5 clk = ~clk;

  pkt_fec_interleaver u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .len_sel   (len_sel),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_last  (out_last)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] expq[$];
  string      tagq[$];
  int         lenq[$];
  int         ocount = 0;
  logic [1:0] e_item;
  string      e_tag;

  bit pdata [256];
  bit cw [516];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid && !out_last)
        chk(in_ready == 1'b0, "R5", "in_ready while draining", int'(in_ready), 0);
      if (out_last)
        chk(out_valid == 1'b1, "R6", "out_last without out_valid", int'(out_valid), 1);
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R6", "unexpected output bit", 1, 0);
        end else begin
          e_item = expq.pop_front();
          e_tag  = tagq.pop_front();
          chk(out_bit == e_item[0], e_tag, "out_bit", int'(out_bit), int'(e_item[0]));
          chk(out_last == e_item[1], "R6", "out_last", int'(out_last), int'(e_item[1]));
          ocount++;
          if (out_last) begin
            if (lenq.size() > 0) begin
              chk(ocount == lenq[0], "R3", "coded bits per packet", ocount, lenq[0]);
              void'(lenq.pop_front());
            end
            ocount = 0;
          end
        end
      end
    end
  end

  task automatic build(input int mode, input int n, input logic [15:0] seed);
    logic [15:0] s;
    s = seed;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: pdata[i] = (i == 0);
        1: pdata[i] = 1'b1;
        2: pdata[i] = i[0];
        default: begin
          pdata[i] = s[0];
          s = {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
        end
      endcase
    end
  endtask

  task automatic expect_pkt(input bit lsel, input string tag);
    int n, len, rows, cols, k;
    bit s1, s2, b;
    n    = lsel ? 256 : 128;
    len  = 2 * (n + 2);
    rows = lsel ? 12 : 4;
    cols = lsel ? 43 : 65;
    s1 = 1'b0;
    s2 = 1'b0;
    for (int i = 0; i < n + 2; i++) begin
      b = (i < n) ? pdata[i] : 1'b0;
      cw[2*i]   = b ^ s1 ^ s2;
      cw[2*i+1] = b ^ s2;
      s2 = s1;
      s1 = b;
    end
    k = 0;
    for (int c = 0; c < cols; c++) begin
      for (int r = 0; r < rows; r++) begin
        int idx;
        idx = r * cols + c;
        if (idx < len) begin
          expq.push_back({(k == len - 1), cw[idx]});
          tagq.push_back(tag);
          k++;
        end
      end
    end
    lenq.push_back(len);
  endtask

  task automatic send_pkt(input int mode, input bit lsel, input logic [15:0] seed,
                          input string tag, input bit hold, input int gap);
    int n;
    n = lsel ? 256 : 128;
    build(mode, n, seed);
    expect_pkt(lsel, tag);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = pdata[i];
      len_sel  = lsel;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    if (hold) begin
      // R5: offer junk and a flipped size while the packet drains
      in_valid = 1'b1;
      in_bit   = 1'b1;
      len_sel  = ~lsel;
      while (!in_ready) @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R8", "out_last in reset", int'(out_last), 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

    send_pkt(0, 1'b0, 16'h0001, "R1", 1'b0, 0);
    send_pkt(1, 1'b1, 16'h0001, "R2", 1'b1, 0);
    send_pkt(2, 1'b0, 16'h0001, "R7", 1'b0, 0);
    send_pkt(3, 1'b1, 16'hACE1, "R4", 1'b0, 3);
    send_pkt(3, 1'b0, 16'h1D2B, "R3", 1'b1, 5);

    for (int t = 0; t < 4000 && expq.size() != 0; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R6", "coded bits still missing", expq.size(), 0);
    chk(lenq.size() == 0, "R6", "packets without end marker", lenq.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule